// File: doc/BRIEF.md
# Covering Table Reduction Engine

This block reduces a small prime-implicant covering table. Each row of the table is a candidate implicant and each column is a minterm that must be covered. A start pulse copies the whole table into an internal bit array. The engine then runs in passes. First it pulls out essential implicants. Next it prunes dominated rows. Last it tests whether any bit is still set. It keeps repeating passes until the table is empty, or until a full pass changes nothing.

Inside the block, a small controller gives one step at a time an active-low enable. It watches that step's result to decide whether to repeat the step or move to the next phase. The outputs are the set of chosen implicants and two flags. `done` marks a table that was fully covered. `stalled` marks a cyclic remainder that the engine leaves for other logic to resolve.

Top module: `cover_reduce`

## Requirements
- R1: A synchronous, active-high reset clears the table, `selected`, `done` and `stalled`.
- R2: A `start` pulse in any state, including the cycle in which `done` is high, does three things. It copies `table_in` into the array, with row r taken from bits [r*COLS +: COLS] and bit c of that slice being column c. It clears `selected` and `stalled`. It begins a new extraction phase.
- R3: During extraction, one column is handled per cycle: the lowest-index column that holds exactly one set bit. The row r holding that bit is recorded by setting `selected[r]`, and every column that row r covers is cleared in all rows. The phase ends when no column holds exactly one set bit.
- R4: During dominance pruning, one row is cleared per cycle. It is the lowest-index non-zero row B whose set bits are all set in some other row A. If A and B are identical, only the higher-index row of the two can be cleared. The phase ends when no such row remains.
- R5: After pruning, an all-zero table ends the run in the stop state. A non-zero table that changed during the pass starts a new extraction phase.
- R6: A non-zero table that went through a full pass unchanged raises `stalled` and halts. `stalled` stays high until the next start, `done` stays low, and `selected` keeps the implicants found so far.
- R7: `done` is high for exactly one cycle, on entry to the stop state. `selected` then holds its value until the next start.
- R8: `done` and `stalled` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load `table_in` and begin a reduction run |
| table_in | input | ROWS*COLS | Covering table, row r in bits [r*COLS +: COLS] |
| selected | output | ROWS | Bit r set when row r was taken as essential |
| done | output | 1 | One-cycle pulse when the table has been fully covered |
| stalled | output | 1 | High when a cyclic remainder stopped the run |

## Verification
A restart and a completion can fall in the same cycle. This happens when `start` is driven high while the one-cycle `done` pulse is visible. The bench provokes it by sampling `done` and raising `start` with a new table before the next edge. After that edge it expects `done` low and `selected` cleared. The new run must then finish with the selection that the second table calls for, with no selection left over from the first run.

// File: rtl/cover_reduce.sv
module cover_reduce #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ROWS*COLS-1:0] table_in,
  output logic [ROWS-1:0]      selected,
  output logic                 done,
  output logic                 stalled
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ESS, S_DOM, S_CHK, S_STOP, S_STALL} st_t;
  st_t st;

  logic [COLS-1:0] tbl [ROWS];
  logic changed;
  logic ess_en_n, dom_en_n;
  logic ess_hit, dom_hit, any_set;
  logic [RW-1:0] ess_row, dom_row;
  logic [COLS-1:0] ess_mask;
  logic [ROWS*COLS-1:0] flat;

  assign ess_en_n = (st != S_ESS);
  assign dom_en_n = (st != S_DOM);

  for (genvar g = 0; g < ROWS; g++) begin : g_flat
    assign flat[g*COLS +: COLS] = tbl[g];
  end
  assign any_set  = |flat;
  assign ess_mask = tbl[ess_row];

  always_comb begin
    int cnt;
    logic [RW-1:0] own;
    ess_hit = 1'b0;
    ess_row = '0;
    for (int c = 0; c < COLS; c++) begin
      cnt = 0;
      own = '0;
      for (int r = 0; r < ROWS; r++)
        if (tbl[r][c]) begin
          cnt = cnt + 1;
          own = RW'(r);
        end
      if (!ess_hit && cnt == 1) begin
        ess_hit = 1'b1;
        ess_row = own;
      end
    end
  end

  always_comb begin
    dom_hit = 1'b0;
    dom_row = '0;
    for (int b = 0; b < ROWS; b++)
      for (int a = 0; a < ROWS; a++)
        if (!dom_hit && a != b && (|tbl[b]) && ((tbl[b] & ~tbl[a]) == '0) &&
            (tbl[a] != tbl[b] || b > a)) begin
          dom_hit = 1'b1;
          dom_row = RW'(b);
        end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      selected <= '0;
      done     <= 1'b0;
      stalled  <= 1'b0;
      changed  <= 1'b0;
      for (int r = 0; r < ROWS; r++) tbl[r] <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        for (int r = 0; r < ROWS; r++) tbl[r] <= table_in[r*COLS +: COLS];
        selected <= '0;
        stalled  <= 1'b0;
        changed  <= 1'b0;
        st       <= S_ESS;
      end else begin
        case (st)
          S_ESS:
            if (!ess_en_n && ess_hit) begin
              for (int r = 0; r < ROWS; r++) tbl[r] <= tbl[r] & ~ess_mask;
              selected[ess_row] <= 1'b1;
              changed <= 1'b1;
            end else st <= S_DOM;
          S_DOM:
            if (!dom_en_n && dom_hit) begin
              tbl[dom_row] <= '0;
              changed <= 1'b1;
            end else st <= S_CHK;
          S_CHK:
            if (!any_set) begin
              st   <= S_STOP;
              done <= 1'b1;
            end else if (!changed) begin
              st      <= S_STALL;
              stalled <= 1'b1;
            end else begin
              changed <= 1'b0;
              st      <= S_ESS;
            end
          default: ;
        endcase
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (selected == '0 && !done && !stalled));
  // R3
  ess_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!ess_en_n && ess_hit && !start) |=> selected[$past(ess_row)]);
  // R4
  dom_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!dom_en_n && dom_hit && !start) |=> (tbl[$past(dom_row)] == '0));
  // R6
  stall_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    stalled |-> any_set);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_STOP && !start) |=> $stable(selected));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && stalled));
endmodule

// File: tb/cover_reduce_tb.sv
module cover_reduce_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] table_in = '0;
  logic [7:0]  selected;
  logic        done, stalled;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cover_reduce u_dut (.clk(clk), .rst(rst), .start(start), .table_in(table_in),
                      .selected(selected), .done(done), .stalled(stalled));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [63:0] t);
    @(negedge clk);
    table_in = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit seen_done, output bit seen_stall);
    seen_done = 0;
    seen_stall = 0;
    for (int i = 0; i < 500; i++) begin
      if (done) begin seen_done = 1; break; end
      if (stalled) begin seen_stall = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [63:0] t, input logic [7:0] exp_sel,
                     input bit exp_done, input string req);
    bit d, s;
    kick(t);
    wait_end(d, s);
    chk(d == exp_done && s == !exp_done, req, {d, s}, {exp_done, !exp_done});
    chk(selected == exp_sel, req, selected, exp_sel);
    if (exp_done) begin
      @(negedge clk);
      chk(!done, "R7 pulse width", done, 0);
      repeat (4) @(negedge clk);
      chk(selected == exp_sel, "R7 hold", selected, exp_sel);
      chk(!stalled, "R8", stalled, 0);
    end else begin
      repeat (4) @(negedge clk);
      chk(stalled && !done, "R6 held", {stalled, done}, 2);
      chk(selected == exp_sel, "R6 partial", selected, exp_sel);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(selected == 0 && !done && !stalled, "R1 reset", {selected, done, stalled}, 0);
  endtask

  task automatic t_restart_on_done;
    bit d, s;
    kick(64'h00000000C0300C03);
    wait_end(d, s);
    chk(d, "R2 first run", d, 1);
    table_in = 64'h0000110000110000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && selected == 0, "R2 restart same cycle", {done, selected}, 0);
    wait_end(d, s);
    chk(d && selected == 8'h04, "R2 restart result", selected, 8'h04);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run(64'h00000000C0300C03, 8'h0F, 1, "R3 essentials");
        run(64'h0000000000060307, 8'h01, 1, "R4 subset prune R5");
        run(64'h0000110000110000, 8'h04, 1, "R4 identical rows");
        run(64'h0000000000050603, 8'h00, 0, "R6 cyclic core");
        run(64'h0000000000000000, 8'h00, 1, "R5 empty table");
        run(64'h0000000008050603, 8'h08, 0, "R6 partial then stall");
        t_restart_on_done();
      end
      begin
        repeat (20000) @(negedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule